// File: doc/BRIEF.md
# Rectangular Blit Address Generator

This block drives the address side of a two-dimensional copy that places a rectangular picture into a framebuffer. All moves are 16-bit transfers. The caller supplies the picture width and height in pixels, the framebuffer row pitch in pixels, the bytes per pixel, the target x/y position and the two base addresses. A start pulse captures all of this. The block then emits one source/destination address pair per transfer under a valid/ready handshake, and raises a completion pulse after the last pair has been taken.

The source side is read as one contiguous stream, so it always steps by 2 bytes. The destination side steps by 2 bytes inside a row. At the end of each row it jumps over the part of the framebuffer row that the picture does not cover. The target x position is rounded down to an even pixel before the start address is formed.

Top module: `blit_addr_gen`

## Requirements
- R1: While reset is held and after it is released, valid_o and done_o are 0.
- R2: A start_i pulse while idle captures the configuration. In the next cycle valid_o is 1, src_addr_o equals src_base_i, and dst_addr_o equals dst_base_i + (x_i with bit 0 cleared)*bpp_i + y_i*pitch*bpp_i.
- R3: A pitch_i value of 0 selects the default pitch of 320 pixels. Any other value is used as given.
- R4: Each row holds floor(width_i*bpp_i/2) pairs. Inside a row, both addresses advance by 2 on every accepted pair.
- R5: On acceptance of the last pair of a row that is not the final row, dst_addr_o advances by (pitch - width_i)*bpp_i + 2 and src_addr_o advances by 2.
- R6: Exactly row_pairs*height_i pairs are issued. After the final pair is accepted, valid_o is 0 in the next cycle, done_o is 1 for exactly that one cycle, and the addresses keep their final values with no further step.
- R7: While valid_o is 1 and ready_i is 0, valid_o, src_addr_o and dst_addr_o hold their values.
- R8: A start_i pulse while a job is active is ignored. This includes the cycle in which the final pair is accepted. The running sequence is unchanged and no new job begins.
- R9: If the row pair count or height_i is zero, a start issues no pairs, and done_o is 1 in the cycle after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the configuration when idle |
| src_base_i | input | 32 | Source start address in bytes |
| dst_base_i | input | 32 | Framebuffer base address in bytes |
| width_i | input | 12 | Picture width in pixels |
| height_i | input | 12 | Picture height in rows |
| pitch_i | input | 12 | Framebuffer row pitch in pixels; 0 selects 320 |
| bpp_i | input | 3 | Bytes per pixel |
| x_i | input | 12 | Target column in pixels; bit 0 is ignored |
| y_i | input | 12 | Target row |
| ready_i | input | 1 | Consumer accepts the current pair |
| valid_o | output | 1 | An address pair is presented |
| src_addr_o | output | 32 | Source byte address |
| dst_addr_o | output | 32 | Destination byte address |
| done_o | output | 1 | One-cycle pulse after the final pair is accepted |

## Verification
The final acceptance of a job and a new start request can land in the same clock cycle. In that cycle the block is still busy, so it must refuse the start while it retires the job. The bench provokes this by raising start_i, with a different configuration, on exactly the cycle in which the last pair is handshaken. It judges the outcome by three observations: done_o must pulse once, valid_o must drop, and valid_o must stay low for several cycles afterwards. A second start during a stall in mid-row checks that the running address stream is not disturbed.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DIM_W  = 12;
  localparam int unsigned BPP_W  = 3;
  localparam int unsigned CNT_W  = DIM_W + BPP_W;
  localparam int unsigned DEF_PITCH = 320;
  localparam int unsigned STEP_BYTES = 2;

  typedef struct packed {
    logic [ADDR_W-1:0] src_base;
    logic [ADDR_W-1:0] dst_start;
    logic [ADDR_W-1:0] dst_row_step;
    logic [CNT_W-1:0]  row_pairs;
    logic [DIM_W-1:0]  rows;
  } job_t;
endpackage

// File: rtl/blit_geom.sv
module blit_geom
  import blit_pkg::*;
#(
  parameter int unsigned DEFAULT_PITCH = DEF_PITCH
) (
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [DIM_W-1:0]  pitch_i,
  input  logic [BPP_W-1:0]  bpp_i,
  input  logic [DIM_W-1:0]  x_i,
  input  logic [DIM_W-1:0]  y_i,
  output job_t              job_o
);
  logic [DIM_W-1:0]  eff_pitch;
  logic [DIM_W-1:0]  x_even;
  logic [CNT_W-1:0]  row_bytes;
  logic [ADDR_W-1:0] bpp_a;

  always_comb begin
    eff_pitch = (pitch_i == '0) ? DIM_W'(DEFAULT_PITCH) : pitch_i;
    x_even    = {x_i[DIM_W-1:1], 1'b0};
    bpp_a     = ADDR_W'(bpp_i);
    row_bytes = CNT_W'(width_i) * CNT_W'(bpp_i);
    job_o.src_base     = src_base_i;
    job_o.dst_start    = dst_base_i + ADDR_W'(x_even) * bpp_a
                       + ADDR_W'(y_i) * ADDR_W'(eff_pitch) * bpp_a;
    job_o.dst_row_step = (ADDR_W'(eff_pitch) - ADDR_W'(width_i)) * bpp_a
                       + ADDR_W'(STEP_BYTES);
    job_o.row_pairs    = row_bytes >> 1;
    job_o.rows         = height_i;
  end
endmodule

// File: rtl/blit_walk.sv
module blit_walk
  import blit_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  job_t              job_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              done_o
);
  job_t              job_q;
  logic              busy_q, done_q;
  logic [CNT_W-1:0]  col_q;
  logic [DIM_W-1:0]  row_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic              take, row_end, last_row, empty_job;

  always_comb begin
    take      = busy_q && ready_i;
    row_end   = (col_q == job_q.row_pairs - CNT_W'(1));
    last_row  = (row_q == job_q.rows - DIM_W'(1));
    empty_job = (job_i.row_pairs == '0) || (job_i.rows == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      job_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      col_q  <= '0;
      row_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          if (empty_job) begin
            done_q <= 1'b1;
          end else begin
            job_q  <= job_i;
            busy_q <= 1'b1;
            col_q  <= '0;
            row_q  <= '0;
            src_q  <= job_i.src_base;
            dst_q  <= job_i.dst_start;
          end
        end
      end else if (take) begin
        if (row_end) begin
          if (last_row) begin
            busy_q <= 1'b0;   // final pair: no modify step
            done_q <= 1'b1;
          end else begin
            col_q <= '0;
            row_q <= row_q + DIM_W'(1);
            src_q <= src_q + ADDR_W'(STEP_BYTES);
            dst_q <= dst_q + job_q.dst_row_step;
          end
        end else begin
          col_q <= col_q + CNT_W'(1);
          src_q <= src_q + ADDR_W'(STEP_BYTES);
          dst_q <= dst_q + ADDR_W'(STEP_BYTES);
        end
      end
    end
  end

  assign valid_o    = busy_q;
  assign src_addr_o = src_q;
  assign dst_addr_o = dst_q;
  assign done_o     = done_q;

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(src_addr_o) && $stable(dst_addr_o));
  assert_src_linear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i |=> !valid_o || (src_addr_o == $past(src_addr_o) + ADDR_W'(STEP_BYTES)));
  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !valid_o);
  assert_busy_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i && start_i |=> valid_o && $stable(dst_addr_o));
  assert_row_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> row_q < job_q.rows && col_q < job_q.row_pairs);
endmodule

// File: rtl/blit_addr_gen.sv
module blit_addr_gen
  import blit_pkg::*;
#(
  parameter int unsigned DEFAULT_PITCH = DEF_PITCH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] src_base_i,
  input  logic [ADDR_W-1:0] dst_base_i,
  input  logic [DIM_W-1:0]  width_i,
  input  logic [DIM_W-1:0]  height_i,
  input  logic [DIM_W-1:0]  pitch_i,
  input  logic [BPP_W-1:0]  bpp_i,
  input  logic [DIM_W-1:0]  x_i,
  input  logic [DIM_W-1:0]  y_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              done_o
);
  job_t job;

  blit_geom #(.DEFAULT_PITCH(DEFAULT_PITCH)) u_geom (
    .src_base_i(src_base_i), .dst_base_i(dst_base_i),
    .width_i(width_i), .height_i(height_i), .pitch_i(pitch_i),
    .bpp_i(bpp_i), .x_i(x_i), .y_i(y_i), .job_o(job)
  );

  blit_walk u_walk (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .job_i(job),
    .ready_i(ready_i), .valid_o(valid_o), .src_addr_o(src_addr_o),
    .dst_addr_o(dst_addr_o), .done_o(done_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !valid_o && !done_o);
endmodule

// File: tb/blit_addr_gen_test.sv
module blit_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] src_base_i = '0, dst_base_i = '0;
  logic [11:0] width_i = '0, height_i = '0, pitch_i = '0, x_i = '0, y_i = '0;
  logic [2:0]  bpp_i = '0;
  logic        ready_i = 1'b0;
  logic        valid_o, done_o;
  logic [31:0] src_addr_o, dst_addr_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  blit_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .src_base_i(src_base_i), .dst_base_i(dst_base_i),
    .width_i(width_i), .height_i(height_i), .pitch_i(pitch_i),
    .bpp_i(bpp_i), .x_i(x_i), .y_i(y_i), .ready_i(ready_i),
    .valid_o(valid_o), .src_addr_o(src_addr_o), .dst_addr_o(dst_addr_o),
    .done_o(done_o)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input int sb, input int db, input int w, input int h,
                      input int p, input int b, input int x, input int y);
    src_base_i = 32'(sb); dst_base_i = 32'(db);
    width_i = 12'(w); height_i = 12'(h); pitch_i = 12'(p);
    bpp_i = 3'(b); x_i = 12'(x); y_i = 12'(y);
  endtask

  // pat: 0 always ready, 1 stall every third cycle
  task automatic run_job(input string tag, input int sb, input int db,
                         input int w, input int h, input int p, input int b,
                         input int x, input int y, input int pat,
                         input bit mid_start, input bit end_start);
    int pitch_e = (p == 0) ? 320 : p;
    int pairs = (w * b) / 2;
    longint exp_src = sb;
    longint exp_dst = db + longint'((x / 2) * 2 * b) + longint'(y) * pitch_e * b;
    int cyc = 0;
    int seen = 0;
    bit mid_done = 0;
    @(negedge clk);
    load(sb, db, w, h, p, b, x, y);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " R2 valid after start"}, valid_o, 1);
    for (int r = 0; r < h; r++) begin
      for (int c = 0; c < pairs; c++) begin
        forever begin
          ready_i = (pat == 1) ? (cyc % 3 != 1) : 1'b1;
          cyc++;
          if (!ready_i && mid_start && !mid_done && seen > 2) begin
            start_i = 1'b1;
            load(sb + 'h100, db + 'h200, w + 1, h, p, b, x + 2, y + 1);
            mid_done = 1;
          end
          if (ready_i) break;
          @(negedge clk);
          start_i = 1'b0;
          check({tag, " R7 valid held in stall"}, valid_o, 1);
          check({tag, " R7/R8 dst held in stall"}, dst_addr_o, 32'(exp_dst));
        end
        check({tag, " R4/R5 src"}, src_addr_o, 32'(exp_src));
        check({tag, " R2/R4/R5 dst"}, dst_addr_o, 32'(exp_dst));
        seen++;
        if (r == h - 1 && c == pairs - 1 && end_start) begin
          start_i = 1'b1;
          load(sb + 'h40, db + 'h80, 2, 2, 8, 2, 0, 0);
        end
        @(negedge clk);
        start_i = 1'b0;
        if (!(r == h - 1 && c == pairs - 1)) begin
          exp_src += 2;
          exp_dst += (c == pairs - 1) ? longint'((pitch_e - w) * b + 2) : 2;
        end
      end
    end
    ready_i = 1'b0;
    check({tag, " R6 done pulse"}, done_o, 1);
    check({tag, " R6 valid low after last"}, valid_o, 0);
    check({tag, " R6 no step after last"}, src_addr_o, 32'(exp_src));
    check({tag, " R6 pair count"}, seen, pairs * h);
    @(negedge clk);
    check({tag, " R6 done one cycle"}, done_o, 0);
    if (end_start) begin
      repeat (3) @(negedge clk);
      check({tag, " R8 start at final accept ignored"}, valid_o, 0);
    end
  endtask

  task automatic empty_job(input string tag, input int w, input int h, input int b);
    @(negedge clk);
    load(0, 'h1000, w, h, 4, b, 0, 0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check({tag, " R9 done"}, done_o, 1);
    check({tag, " R9 no pair"}, valid_o, 0);
    @(negedge clk);
    check({tag, " R9 stays idle"}, valid_o, 0);
  endtask

  task automatic reset_check();
    #1;
    check("R1 valid in reset", valid_o, 0);
    check("R1 done in reset", done_o, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", valid_o, 0);
    check("R1 done after reset", done_o, 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    reset_check();
    run_job("basic", 'h4000, 'h8000, 4, 3, 10, 2, 3, 2, 0, 0, 0);
    run_job("stall", 'h100, 'h20000, 5, 2, 16, 3, 6, 1, 1, 1, 0);
    run_job("R3 default pitch", 'h10, 'h0, 2, 2, 0, 2, 1, 1, 0, 0, 0);
    run_job("collide", 'h200, 'h3000, 2, 2, 6, 2, 4, 0, 1, 0, 1);
    empty_job("narrow", 1, 3, 1);
    empty_job("flat", 4, 0, 2);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule